// File: doc/BRIEF.md
# Windowed Pixel-Write Command Engine

This block sits behind a byte-serial link to a small greyscale panel. Every byte arrives with a level on a command/data select input. A data byte carries two 4-bit pixels and is written into a frame buffer that is 64 bytes wide and 80 rows tall. The write goes out on a single-cycle write port toward a dual-port RAM. Its address is computed from a column pointer and a row pointer. After each write the pointers step forward inside a programmable rectangle. They run either column-first or row-first, and they wrap at the window edges.

A command byte starts a small opcode parser. The parser waits for the argument bytes that the opcode needs and then executes the opcode. Three opcodes have a visible effect: the column window, the row window and the remap register. Settings for the analog panel are consumed with their arguments and then dropped. The block keeps a sticky flag for opcodes it does not recognise. Scan-out of the buffer is handled elsewhere.

Top module: `oled_cmd_engine`

## Requirements
- R1: A valid byte with `dcSel` high is written at once: `fbWe`=1, `fbData`=`byteIn`, and `fbAddr` = column + row*64 from the current pointers. A byte with `dcSel` low never asserts `fbWe`.
- R2: After reset, no write is pending, `remapOut`=0 and `unknownCmd`=0. Both pointers are 0, and the window spans columns 0..63 and rows 0..79.
- R3: Opcode 0x15 takes two arguments. The first, modulo 64, loads both the column start and the column pointer. The second, modulo 64, loads the column end.
- R4: Opcode 0x75 takes two arguments. The first, modulo 80, loads both the row start and the row pointer. The second, modulo 80, loads the row end.
- R5: Opcode 0xA0 takes one argument, which is stored in full and shown on `remapOut`.
- R6: With `remapOut` bit 2 clear, each write increments the column. A column passing its end reloads the column start and increments the row. A row passing its end reloads the row start.
- R7: With `remapOut` bit 2 set, each write increments the row. A row passing its end reloads the row start and increments the column. A column passing its end reloads the column start.
- R8: Opcode 0xB8 consumes eight argument bytes. Opcodes 0x81, 0x84-0x86, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1-0xB3, 0xBC, 0xBE and 0xBF each consume one argument byte. None of them changes the pointers, the window, the remap register or the flag.
- R9: Opcodes 0xA4-0xA7, 0xAE, 0xAF, 0xE3 and 0xFF take no argument and have no effect. The next command byte is parsed as a new opcode.
- R10: Any other opcode takes no argument and sets `unknownCmd`, which stays set until reset.
- R11: A data byte, or any change of the `dcSel` level, abandons a command whose arguments are incomplete. The next command byte is then parsed as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Qualifies `byteIn` for one cycle |
| byteIn | input | 8 | Received byte |
| dcSel | input | 1 | 1 = pixel data, 0 = command |
| fbWe | output | 1 | Frame buffer write enable |
| fbAddr | output | 13 | Frame buffer byte address (column + row*64) |
| fbData | output | 8 | Frame buffer write data (two pixels) |
| remapOut | output | 8 | Current remap register |
| unknownCmd | output | 1 | Sticky unrecognised-opcode flag |

## Verification
A wrong pointer or window register shows on `fbAddr` at the first data byte after the fault. Every following write then lands at a shifted address, so the scoreboard catches it within one transfer. A parser that keeps the wrong argument count swallows or misreads the opcode that follows. This shows up as a later write address or `remapOut` value that does not match. Mis-decoding an opcode shows on `unknownCmd` in the cycle after the byte.

// File: rtl/oled_eng_pkg.sv
package oled_eng_pkg;
  localparam int unsigned MAX_ARGS = 8;
  localparam int unsigned ARGC_W = $clog2(MAX_ARGS + 1);

  typedef struct packed {
    logic       setCol;
    logic       setRow;
    logic       setRemap;
    logic       wrData;
    logic [7:0] arg0;
    logic [7:0] arg1;
  } ctrlStrobes_t;

  typedef enum logic {PS_IDLE, PS_ARGS} parseState_t;
endpackage

// File: rtl/oled_parse_ctrl.sv
module oled_parse_ctrl
  import oled_eng_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic [7:0]   byteIn,
  input  logic         dcSel,
  output ctrlStrobes_t strobes,
  output logic         unknownCmd
);
  parseState_t stateQ, stateEff;
  logic [7:0]        opQ, execOp, arg0Q;
  logic [ARGC_W-1:0] needQ, argCntQ, needNew;
  logic              knownNew, isCmd, execNow, dcPrevQ, unknownQ;

  // {known, argument count} for an opcode
  function automatic logic [ARGC_W:0] opInfo(input logic [7:0] op);
    case (op)
      8'h15, 8'h75:                            opInfo = {1'b1, ARGC_W'(2)};
      8'hB8:                                   opInfo = {1'b1, ARGC_W'(MAX_ARGS)};
      8'hA0, 8'h81, 8'h84, 8'h85, 8'h86,
      8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1,
      8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:       opInfo = {1'b1, ARGC_W'(1)};
      8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE,
      8'hAF, 8'hE3, 8'hFF:                     opInfo = {1'b1, ARGC_W'(0)};
      default:                                 opInfo = {1'b0, ARGC_W'(0)};
    endcase
  endfunction

  always_comb begin
    {knownNew, needNew} = opInfo(byteIn);
    isCmd    = byteValid && !dcSel;
    stateEff = (dcSel != dcPrevQ) ? PS_IDLE : stateQ;
    execNow  = 1'b0;
    execOp   = opQ;
    if (isCmd) begin
      if (stateEff == PS_IDLE) begin
        execNow = (needNew == '0);
        execOp  = byteIn;
      end else begin
        execNow = ((argCntQ + 1'b1) == needQ);
      end
    end
    strobes        = '0;
    strobes.wrData = byteValid && dcSel;
    strobes.arg0   = (stateEff == PS_ARGS && argCntQ != '0) ? arg0Q : byteIn;
    strobes.arg1   = byteIn;
    if (execNow) begin
      strobes.setCol   = (execOp == 8'h15);
      strobes.setRow   = (execOp == 8'h75);
      strobes.setRemap = (execOp == 8'hA0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= PS_IDLE;
      opQ      <= '0;
      needQ    <= '0;
      argCntQ  <= '0;
      arg0Q    <= '0;
      dcPrevQ  <= 1'b0;
      unknownQ <= 1'b0;
    end else begin
      dcPrevQ <= dcSel;
      if (stateEff != stateQ) stateQ <= stateEff;
      if (byteValid && dcSel) stateQ <= PS_IDLE;
      if (isCmd) begin
        if (stateEff == PS_IDLE) begin
          if (!knownNew) unknownQ <= 1'b1;
          if (needNew != '0) begin
            stateQ  <= PS_ARGS;
            opQ     <= byteIn;
            needQ   <= needNew;
            argCntQ <= '0;
          end
        end else begin
          if (argCntQ == '0) arg0Q <= byteIn;
          argCntQ <= argCntQ + 1'b1;
          if (execNow) stateQ <= PS_IDLE;
        end
      end
    end
  end

  assign unknownCmd = unknownQ;

  assert_sticky_unknown_R10: assert property (@(posedge clk) disable iff (!rstN)
    unknownQ |=> unknownQ);
  assert_cfg_only_in_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setCol || strobes.setRow || strobes.setRemap) |-> !dcSel);
  assert_args_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_ARGS) |-> (argCntQ < needQ));
endmodule

// File: rtl/oled_addr_dp.sv
module oled_addr_dp
  import oled_eng_pkg::*;
#(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  parameter int unsigned VERT_BIT = 2,
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [7:0]        remapOut
);
  logic [COL_W-1:0] colQ, colStartQ, colEndQ, colArg0, colArg1;
  logic [ROW_W-1:0] rowQ, rowStartQ, rowEndQ, rowArg0, rowArg1;
  logic [COL_W:0]   colInc;
  logic [ROW_W:0]   rowInc;
  logic             colPast, rowPast, vertical;

  always_comb begin
    colArg0  = COL_W'(32'(strobes.arg0) % COLS);
    colArg1  = COL_W'(32'(strobes.arg1) % COLS);
    rowArg0  = ROW_W'(32'(strobes.arg0) % ROWS);
    rowArg1  = ROW_W'(32'(strobes.arg1) % ROWS);
    colInc   = {1'b0, colQ} + 1'b1;
    rowInc   = {1'b0, rowQ} + 1'b1;
    colPast  = colInc > {1'b0, colEndQ};
    rowPast  = rowInc > {1'b0, rowEndQ};
    vertical = remapOut[VERT_BIT];
    fbAddr   = ADDR_W'(rowQ) * ADDR_W'(COLS) + ADDR_W'(colQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ <= '0; colStartQ <= '0; colEndQ <= COL_W'(COLS - 1);
      rowQ <= '0; rowStartQ <= '0; rowEndQ <= ROW_W'(ROWS - 1);
      remapOut <= '0;
    end else begin
      if (strobes.setCol) begin
        colQ <= colArg0; colStartQ <= colArg0; colEndQ <= colArg1;
      end
      if (strobes.setRow) begin
        rowQ <= rowArg0; rowStartQ <= rowArg0; rowEndQ <= rowArg1;
      end
      if (strobes.setRemap) remapOut <= strobes.arg0;
      if (strobes.wrData) begin
        if (vertical) begin
          rowQ <= rowPast ? rowStartQ : rowInc[ROW_W-1:0];
          if (rowPast) colQ <= colPast ? colStartQ : colInc[COL_W-1:0];
        end else begin
          colQ <= colPast ? colStartQ : colInc[COL_W-1:0];
          if (colPast) rowQ <= rowPast ? rowStartQ : rowInc[ROW_W-1:0];
        end
      end
    end
  end

  assert_row_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rowQ < ROWS) && (rowStartQ < ROWS) && (rowEndQ < ROWS));
  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrData && !vertical && colQ < colEndQ) |=> (colQ == $past(colQ) + 1'b1));
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrData && vertical && rowQ < rowEndQ) |=> (rowQ == $past(rowQ) + 1'b1));
  assert_row_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrData && !vertical && colQ == colEndQ && rowQ == rowEndQ && colStartQ <= colEndQ)
    |=> (rowQ == $past(rowStartQ)));
endmodule

// File: rtl/oled_cmd_engine.sv
module oled_cmd_engine
  import oled_eng_pkg::*;
#(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  localparam int unsigned ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic              dcSel,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [7:0]        fbData,
  output logic [7:0]        remapOut,
  output logic              unknownCmd
);
  ctrlStrobes_t strobes;

  oled_parse_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .dcSel(dcSel), .strobes(strobes), .unknownCmd(unknownCmd)
  );

  oled_addr_dp #(.COLS(COLS), .ROWS(ROWS), .VERT_BIT(2)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fbAddr(fbAddr), .remapOut(remapOut)
  );

  assign fbWe   = strobes.wrData;
  assign fbData = byteIn;
endmodule

// File: tb/oled_cmd_engine_tb_top.sv
module oled_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic dcSel = 1'b0;
  logic fbWe, unknownCmd;
  logic [12:0] fbAddr;
  logic [7:0] fbData, remapOut;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [20:0] expQ[$];   // {addr, data}
  string tagQ[$];

  always #4 clk = ~clk;

  oled_cmd_engine dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn), .dcSel(dcSel),
    .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData), .remapOut(remapOut),
    .unknownCmd(unknownCmd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic dc, input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1; dcSel = dc; byteIn = b;
    @(posedge clk);
    #1 byteValid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    sendByte(1'b0, b);
  endtask

  task automatic pix(input string req, input int col, input int row, input logic [7:0] d);
    expQ.push_back({13'(col + row * 64), d});
    tagQ.push_back(req);
    sendByte(1'b1, d);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (fbWe) begin
      if (expQ.size() == 0) check("R1", {19'h0, fbAddr}, 32'hFFFF);
      else begin
        logic [20:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {19'h0, fbAddr}, {19'h0, e[20:8]});
        check(t, {24'h0, fbData}, {24'h0, e[7:0]});
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R2", {31'h0, fbWe}, 0);
    check("R2", {24'h0, remapOut}, 0);
    check("R2", {31'h0, unknownCmd}, 0);
    pix("R2", 0, 0, 8'h12);
    pix("R1", 1, 0, 8'h34);
    // R3/R4 modulo, R6 horizontal wrap
    cmd(8'h15); cmd(8'h7E); cmd(8'hFF);   // cols 62..63
    cmd(8'h75); cmd(8'hA6); cmd(8'h07);   // rows 6..7
    pix("R3", 62, 6, 8'hA1);
    pix("R6", 63, 6, 8'hA2);
    pix("R6", 62, 7, 8'hA3);
    pix("R4", 63, 7, 8'hA4);
    pix("R6", 62, 6, 8'hA5);
    // R5, R7 vertical order
    cmd(8'hA0); cmd(8'h04);
    #2 check("R5", {24'h0, remapOut}, 32'h04);
    cmd(8'h15); cmd(8'd10); cmd(8'd11);
    cmd(8'h75); cmd(8'd78); cmd(8'd79);
    pix("R7", 10, 78, 8'h51);
    pix("R7", 10, 79, 8'h52);
    pix("R7", 11, 78, 8'h53);
    pix("R7", 11, 79, 8'h54);
    pix("R7", 10, 78, 8'h55);
    cmd(8'hA0); cmd(8'h00);
    // R8 / R9 ignored opcodes
    cmd(8'h15); cmd(8'd5); cmd(8'd5);
    cmd(8'h75); cmd(8'd2); cmd(8'd2);
    cmd(8'h81); cmd(8'h15);
    cmd(8'hA4);
    cmd(8'hB8);
    for (int i = 0; i < 8; i++) cmd(8'h75);
    cmd(8'hE3); cmd(8'hFF); cmd(8'hBF); cmd(8'hA0);
    pix("R8", 5, 2, 8'h61);
    #2 check("R8", {24'h0, remapOut}, 0);
    check("R9", {31'h0, unknownCmd}, 0);
    pix("R9", 5, 2, 8'h62);
    // R11 abort by data byte and by dcSel change
    cmd(8'h15); cmd(8'd20);
    pix("R11", 5, 2, 8'h71);
    cmd(8'hA0); cmd(8'h04);
    #2 check("R11", {24'h0, remapOut}, 32'h04);
    cmd(8'h75);
    @(negedge clk); dcSel = 1'b1;
    @(negedge clk);
    cmd(8'hA0); cmd(8'h00);
    #2 check("R11", {24'h0, remapOut}, 0);
    // R10 unknown opcode
    cmd(8'h42);
    #2 check("R10", {31'h0, unknownCmd}, 1);
    cmd(8'h15); cmd(8'd1); cmd(8'd1);
    pix("R10", 1, 2, 8'h81);
    cmd(8'hE3);
    #2 check("R10", {31'h0, unknownCmd}, 1);
    repeat (3) @(negedge clk);
    check("R1", expQ.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule